// File: doc/BRIEF.md
# Byte-Register I2C Master Controller

This block is an I2C bus master that a host drives through a small byte-wide register window. The host loads a target address and a data byte, then writes a control value. The controller then produces START, address, data, repeated START and STOP on two open-drain lines. The `scl_oe` and `sda_oe` outputs pull a line low when they are 1. The `scl_i` and `sda_i` inputs return the wired level of each line.

A write transfer opens when the data register is written while the bus is free. The controller keeps the bus held with SCL low, so each further data write sends one more byte. A control write with start set and read clear closes the transfer. A read uses a pending-byte field in the control register. Each byte is fetched under its own address phase and ends with a master NACK. Each host read of the data register consumes one byte. While bytes remain pending, that host read also re-addresses the target with a repeated START. A target that does not acknowledge sets an error flag and an abort flag, and the bus is released.

One bit period is four quarter periods of `CLK_DIV` system clocks each. The host read data is combinational on `reg_rdata` during the cycle of `reg_rd`. Any side effect of the read takes place at the clock edge that ends that cycle.

Top module: `i2c_host_ctl`

## Requirements
- R1: After reset `busy` is 0 and both line enables are 0. Every register reads 0, except the line register, which reads 0x0F while both lines are high.
- R2: Writing DATA while the bus is free (not held) does three things. It issues START, then the address byte {ADDR[7:1], 0}, then the data byte. It sets STAT bit0 (transfer open) at launch. On ACK it leaves the bus held with SCL driven low.
- R3: Writing DATA while the bus is held sends only that byte, with no new START.
- R4: Writing CTRL with bit0=1 and bit1=0 clears STAT bit0. If the bus is held, it also issues STOP and releases both lines.
- R5: A NACK on an address or a write data byte does four things. It sets STAT bit2 (error), clears STAT bit0 and sets XSTAT bit0 (aborted). It then issues STOP, leaving both lines released.
- R6: Writing CTRL with bit0=1 and bit1=1 issues START (a repeated START if the bus is held) and then the address byte {ADDR[7:1], 1}. On ACK it clears STAT bit2 and reads one byte, answering it with NACK. It then sets STAT bit5 (byte ready). If CTRL[5:4] (pending count) is 0 it issues STOP, otherwise it keeps the bus held.
- R7: A DATA read while STAT bit5 is set returns the received byte. If the pending count is 0, the read clears bit5. Otherwise the read decrements the count and fetches the next byte after a repeated START. A read started with count N yields N+1 bytes and one STOP.
- R8: Writing STAT leaves bits 0, 2 and 5 unchanged, because the write can clear only bits under 0x0A. Writing XSTAT with 1 in bit0 clears the aborted flag, because XSTAT clears under mask 0x8F.
- R9: MODE stores the written value ANDed with 0xDF. XCNT stores the written value ANDed with 0x77.
- R10: Writing XCTL with bit0=1 resets every register and the bus engine at once, even in the middle of a transfer. XCTL stores any other written value.
- R11: While `busy` is 1, writes to DATA and CTRL have no effect.
- R12: SDA changes only while SCL is low, except in START and STOP. One SCL period lasts 4*CLK_DIV clocks.
- R13: Register offsets are DATA 0, ADDR 1, CTRL 2, MODE 3, STAT 4, XSTAT 5, XCTL 6, XCNT 7 and line register 8 ({4'b0, 2'b11, SDA, SCL}). Other offsets in the 18-byte window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, same cycle |
| busy | output | 1 | Bus engine running a sequence |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench runs a behavioural target on the wired lines and checks it against a queue of expected write bytes. A controller that re-addressed on every write byte would raise the start count. One that acted on commands while busy would deliver a byte the queue does not expect. A chained read with a pending count of two must yield exactly three bytes in order, with three STARTs and one STOP. An off-by-one in the counter would change either number. The bench also checks that a status write leaves the error flag set and that a NACK in either the address or the data phase sets both flags. It further checks that a soft reset in the middle of a byte frees the lines at once and that a later transfer still succeeds.

// File: rtl/i2c_host_ctl.sv
module i2c_host_ctl #(
  parameter int CLK_DIV = 4,
  parameter int AW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          busy,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int DW = $clog2(CLK_DIV) + 1;
  localparam logic [AW-1:0] A_DATA = AW'(0), A_TADR = AW'(1), A_CTRL = AW'(2),
    A_MODE = AW'(3), A_STAT = AW'(4), A_XSTA = AW'(5), A_XCTL = AW'(6),
    A_XCNT = AW'(7), A_LINE = AW'(8);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_START, S_BIT, S_STOP} st_t;
  typedef enum logic [1:0] {J_ADDR, J_WDAT, J_RDAT} job_t;

  st_t        st;
  job_t       job;
  logic       rdm, scl_lo, sda_lo, pt, err, mdbs, xfra;
  logic [1:0] q, pend, ctl_hi;
  logic [3:0] ctl_lo, bitn;
  logic [DW-1:0] dcnt;
  logic [8:0] tx, rx;
  logic [7:0] taddr, wdat, rbuf, mode, xcnt, xctl;

  wire active = (st == S_START) || (st == S_BIT) || (st == S_STOP);
  wire tick   = (dcnt == DW'(CLK_DIV - 1));
  wire srst   = reg_wr && reg_addr == A_XCTL && reg_wdata[0];
  wire wr_dat = reg_wr && reg_addr == A_DATA && !active;
  wire wr_ctl = reg_wr && reg_addr == A_CTRL && !active;
  wire rd_dat = reg_rd && reg_addr == A_DATA && mdbs && !active;

  assign busy   = active;
  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rbuf;
      A_TADR:  reg_rdata = taddr;
      A_CTRL:  reg_rdata = {ctl_hi, pend, ctl_lo};
      A_MODE:  reg_rdata = mode;
      A_STAT:  reg_rdata = {2'b00, mdbs, 2'b00, err, 1'b0, pt};
      A_XSTA:  reg_rdata = {7'd0, xfra};
      A_XCTL:  reg_rdata = xctl;
      A_XCNT:  reg_rdata = xcnt;
      A_LINE:  reg_rdata = {4'h0, 2'b11, sda_i, scl_i};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE; job <= J_ADDR; rdm <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
      pt <= 1'b0; err <= 1'b0; mdbs <= 1'b0; xfra <= 1'b0;
      q <= '0; pend <= '0; ctl_hi <= '0; ctl_lo <= '0; bitn <= '0; dcnt <= '0;
      tx <= '1; rx <= '0; taddr <= '0; wdat <= '0; rbuf <= '0;
      mode <= '0; xcnt <= '0; xctl <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_TADR: taddr <= reg_wdata;
          A_MODE: mode  <= reg_wdata & 8'hDF;
          A_XCNT: xcnt  <= reg_wdata & 8'h77;
          A_XCTL: xctl  <= reg_wdata;
          A_XSTA: if (reg_wdata[0]) xfra <= 1'b0;
          default: ;
        endcase
      end
      if (wr_dat) begin
        wdat <= reg_wdata;
        q <= '0; dcnt <= '0;
        if (st == S_IDLE) begin
          pt <= 1'b1; rdm <= 1'b0; job <= J_ADDR; st <= S_START;
        end else begin
          job <= J_WDAT; tx <= {reg_wdata, 1'b1}; bitn <= '0; st <= S_BIT;
        end
      end
      if (wr_ctl) begin
        ctl_hi <= reg_wdata[7:6]; pend <= reg_wdata[5:4]; ctl_lo <= reg_wdata[3:0];
        q <= '0; dcnt <= '0;
        if (reg_wdata[0]) begin
          pt <= 1'b0;
          if (reg_wdata[1]) begin
            rdm <= 1'b1; job <= J_ADDR; st <= S_START;
          end else if (st == S_HOLD) begin
            st <= S_STOP;
          end
        end
      end
      if (rd_dat) begin
        if (pend == 2'd0) mdbs <= 1'b0;
        else begin
          pend <= pend - 2'd1; rdm <= 1'b1; job <= J_ADDR; st <= S_START;
          q <= '0; dcnt <= '0;
        end
      end
      if (active) begin
        if (!tick) dcnt <= dcnt + 1'b1;
        else begin
          dcnt <= '0;
          q    <= q + 2'd1;
          case (st)
            S_START: case (q)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1; st <= S_BIT; bitn <= '0;
                tx <= {taddr[7:1], rdm, 1'b1};
              end
            endcase
            S_BIT: case (q)
              2'd0: sda_lo <= ~tx[8];
              2'd1: scl_lo <= 1'b0;
              2'd2: rx <= {rx[7:0], sda_i};
              default: begin
                scl_lo <= 1'b1;
                tx     <= {tx[7:0], 1'b1};
                bitn   <= bitn + 4'd1;
                if (bitn == 4'd8) begin
                  bitn <= '0;
                  if (job != J_RDAT && rx[0]) begin
                    err <= 1'b1; xfra <= 1'b1; pt <= 1'b0; st <= S_STOP;
                  end else if (job == J_ADDR) begin
                    err <= 1'b0;
                    job <= rdm ? J_RDAT : J_WDAT;
                    tx  <= rdm ? 9'h1FF : {wdat, 1'b1};
                  end else if (job == J_WDAT) begin
                    st <= S_HOLD;
                  end else begin
                    rbuf <= rx[8:1]; mdbs <= 1'b1;
                    st <= (pend == 2'd0) ? S_STOP : S_HOLD;
                  end
                end
              end
            endcase
            S_STOP: case (q)
              2'd0: sda_lo <= 1'b1;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: st <= S_IDLE;
            endcase
            default: ;
          endcase
        end
      end
    end
  end

  // R12
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && !scl_lo && $past(!scl_lo)) |-> $stable(sda_lo));
  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_lo && !sda_lo));
  // R5
  nack_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfra) |-> (err && !pt));
  // R7
  pend_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend > $past(pend)) |-> $past(reg_wr && reg_addr == A_CTRL));
  // R8
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == A_STAT && !active) |->
      (err == $past(err) && pt == $past(pt) && mdbs == $past(mdbs)));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active && reg_wr && reg_addr == A_CTRL) |-> (pend == $past(pend)));
endmodule

// File: tb/sim_i2c_host_ctl.sv
module sim_i2c_host_ctl;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic busy, scl_oe, sda_oe;
  logic slv_lo = 1'b0, slv_nack = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || slv_lo);

  i2c_host_ctl #(.CLK_DIV(DIV), .AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_start = 0, n_stop = 0, n_wb = 0;
  longint cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural target at 7-bit address 0x50
  int bc = 0;
  logic started = 0, in_addr = 0, sel = 0, rdir = 0, mack = 0;
  logic [7:0] sh = '0, txb = '0, rd_val = '0;
  always @(negedge sda_w) if (scl_w) begin
    started = 1; bc = -1; in_addr = 1; sel = 0; slv_lo = 0; n_start++;
  end
  always @(posedge sda_w) if (scl_w && started) begin
    started = 0; sel = 0; slv_lo = 0; n_stop++;
  end
  always @(posedge scl_w) if (started) begin
    if (bc >= 0 && bc < 8) sh = {sh[6:0], sda_w};
    else if (bc == 8) mack = sda_w;
  end
  always @(negedge scl_w) if (started) begin
    if (bc == 8) begin
      bc = 0; slv_lo = 0;
      if (in_addr) begin in_addr = 0; sel = (sh[7:1] == 7'h50); rdir = sh[0]; end
      else if (rdir && mack) sel = 0;
      else if (!rdir && slv_nack) sel = 0;
      if (sel && rdir) begin txb = rd_val; rd_val = rd_val + 8'h11; slv_lo = !txb[7]; end
    end else begin
      bc = bc + 1;
      if (bc == 8) begin
        if (in_addr) slv_lo = (sh[7:1] == 7'h50);
        else if (sel && !rdir) begin
          n_wb++;
          if (exp_q.size() == 0) chk("R2/R3/R11 unexpected byte", {24'd0, sh}, 32'hFFFF_FFFF);
          else chk("R2/R3 scoreboard", {24'd0, sh}, {24'd0, exp_q.pop_front()});
          slv_lo = !slv_nack;
        end else slv_lo = 0;
      end else if (bc > 0 && sel && rdir && !in_addr) slv_lo = !txb[7-bc];
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    wr(5'd0, b);
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask
  task automatic rchk(input string req, input logic [4:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'd0, v}, {24'd0, e});
  endtask

  function automatic void summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0, p0;
    longint t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R13 line register offset
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 lines", {30'd0, scl_oe, sda_oe}, 0);
    rchk("R1 STAT", 5'd4, 8'h00);
    rchk("R1 CTRL", 5'd2, 8'h00);
    rchk("R1 R13 LINE", 5'd8, 8'h0F);

    // R2 write transfer opens
    wr(5'd1, 8'hA0);
    send_byte(8'h3C);
    wait_idle();
    rchk("R2 STAT open", 5'd4, 8'h01);
    chk("R2 SCL held", {31'd0, scl_oe}, 1);
    chk("R2 starts", n_start, 1);

    // R3 byte on held bus, R12 SCL period
    send_byte(8'h81);
    @(posedge scl_w); t0 = cyc;
    @(posedge scl_w);
    chk("R12 SCL period", 32'(cyc - t0), 4 * DIV);
    wait_idle();
    chk("R3 no new START", n_start, 1);
    chk("R12 no spurious STOP", n_stop, 0);

    // R4 close transfer
    wr(5'd2, 8'h01);
    wait_idle();
    rchk("R4 STAT", 5'd4, 8'h00);
    chk("R4 lines released", {30'd0, scl_oe, sda_oe}, 0);
    chk("R4 stop", n_stop, 1);

    // R11 commands while busy ignored
    send_byte(8'h5A);
    wr(5'd0, 8'hEE);
    wr(5'd2, 8'h33);
    wait_idle();
    rchk("R11 CTRL unchanged", 5'd2, 8'h01);
    chk("R11 one byte only", n_wb, 3);
    wr(5'd2, 8'h01);
    wait_idle();

    // R5 address NACK
    p0 = n_stop;
    wr(5'd1, 8'hB2);
    wr(5'd0, 8'h55);
    wait_idle();
    rchk("R5 STAT", 5'd4, 8'h04);
    rchk("R5 XSTAT", 5'd5, 8'h01);
    chk("R5 lines", {30'd0, scl_oe, sda_oe}, 0);
    chk("R5 stop", n_stop, p0 + 1);

    // R8 status write keeps flags, XSTAT clears
    wr(5'd4, 8'hFF);
    rchk("R8 STAT kept", 5'd4, 8'h04);
    wr(5'd5, 8'h01);
    rchk("R8 XSTAT cleared", 5'd5, 8'h00);

    // R5 data NACK
    wr(5'd1, 8'hA0);
    slv_nack = 1;
    send_byte(8'h77);
    wait_idle();
    slv_nack = 0;
    rchk("R5 data STAT", 5'd4, 8'h04);
    rchk("R5 data XSTAT", 5'd5, 8'h01);
    wr(5'd5, 8'h01);

    // R6 R7 chained read, pending 2
    rd_val = 8'hC3;
    s0 = n_start; p0 = n_stop;
    wr(5'd2, 8'h23);
    wait_idle();
    rchk("R6 STAT ready", 5'd4, 8'h20);
    chk("R6 bus held", {31'd0, scl_oe}, 1);
    rchk("R7 byte1", 5'd0, 8'hC3);
    rchk("R7 CTRL count", 5'd2, 8'h13);
    wait_idle();
    rchk("R7 byte2", 5'd0, 8'hD4);
    wait_idle();
    chk("R7 one STOP", n_stop, p0 + 1);
    chk("R7 repeated STARTs", n_start, s0 + 3);
    rchk("R7 byte3", 5'd0, 8'hE5);
    rchk("R7 STAT drained", 5'd4, 8'h00);

    // R6 read address NACK
    wr(5'd1, 8'hB3);
    wr(5'd2, 8'h03);
    wait_idle();
    rchk("R6 nack STAT", 5'd4, 8'h04);
    rchk("R6 nack XSTAT", 5'd5, 8'h01);

    // R9 masks, R13 unmapped
    wr(5'd3, 8'hFF); rchk("R9 MODE", 5'd3, 8'hDF);
    wr(5'd7, 8'hFF); rchk("R9 XCNT", 5'd7, 8'h77);
    wr(5'd6, 8'h06); rchk("R10 XCTL store", 5'd6, 8'h06);
    rchk("R13 unmapped", 5'd17, 8'h00);

    // R10 soft reset when idle
    wr(5'd6, 8'h01);
    rchk("R10 ADDR", 5'd1, 8'h00);
    rchk("R10 MODE", 5'd3, 8'h00);
    rchk("R10 XCNT", 5'd7, 8'h00);
    rchk("R10 XSTAT", 5'd5, 8'h00);
    rchk("R10 STAT", 5'd4, 8'h00);
    rchk("R10 XCTL", 5'd6, 8'h00);
    rchk("R10 LINE", 5'd8, 8'h0F);

    // R10 soft reset mid-transfer
    wr(5'd1, 8'hA0);
    wr(5'd0, 8'h99);
    repeat (20) @(negedge clk);
    wr(5'd6, 8'h01);
    chk("R10 busy dropped", {31'd0, busy}, 0);
    chk("R10 lines freed", {30'd0, scl_oe, sda_oe}, 0);
    started = 0; slv_lo = 0; sel = 0;
    wr(5'd1, 8'hA0);
    send_byte(8'h42);
    wait_idle();
    rchk("R10 recovered STAT", 5'd4, 8'h01);
    wr(5'd2, 8'h01);
    wait_idle();
    chk("R2 queue empty", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule